// File: doc/BRIEF.md
# Requester ID to Partition Matcher

This block keeps a small table of partition rules and classifies 16-bit requester IDs against it. Each rule holds a partition number, a base bus/device/function value and a set of compare controls. A single rule can therefore cover a whole range of requesters rather than one exact ID. Software installs or removes a rule through a write port that takes a map or unmap command. Each command returns a status one cycle later.

The lookup port takes a requester ID and, one cycle later, reports whether any valid rule accepts it and which partition that rule belongs to. Every rule runs its comparison in parallel. A fixed priority picks the lowest-numbered matching rule. The requester ID is split as bus in bits 15:8, device in bits 7:3 and function in bits 2:0.

Top module: `reqid_part_match`

## Requirements
- R1: A rule whose bus compare code is 0 accepts every bus number.
- R2: A bus compare code n in the range 2 to 6 compares only the n+1 most significant bits of the requester bus with the rule's bus.
- R3: A bus compare code of 7 requires all 8 bus bits to be equal.
- R4: A device compare value of zero ignores the device field. Any non-zero value requires the 5-bit device field to match exactly.
- R5: A function compare value of zero ignores the function field. Any non-zero value requires the 3-bit function field to match exactly.
- R6: Command code 1 maps (installs) the rule and code 0 unmaps it, both with status 0. Codes 2 and 3 return status 1 (parameter error) and leave the table unchanged.
- R7: A map command whose bus compare code is 1 or 8 to 15 returns status 1 and leaves the table unchanged. An unmap command does not check the code.
- R8: The requester ID fields are taken as bus = bits 15:8, device = bits 7:3 and function = bits 2:0, both for the rule base and for the lookup.
- R9: `lk_done` pulses exactly one cycle after `lk_valid`, carrying the hit flag and partition. With no request, `lk_done` and `lk_hit` stay low. A lookup sees the table as it stood before a write issued in the same cycle.
- R10: When several valid rules accept the ID, the lowest-index rule supplies the partition.
- R11: After reset no rule is valid. An unmapped rule never produces a hit, and a miss returns partition 0.
- R12: `wr_done` pulses exactly one cycle after `wr_valid`, with the status on `wr_status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Command strobe |
| wr_index | input | IDX_W | Rule slot to write |
| wr_action | input | 2 | 0 unmap, 1 map, others invalid |
| wr_part | input | PART_W | Partition number for the rule |
| wr_rid | input | 16 | Base bus/device/function |
| wr_bus_code | input | 4 | Bus compare code |
| wr_dev_cmp | input | 8 | Non-zero enables the device compare |
| wr_func_cmp | input | 8 | Non-zero enables the function compare |
| wr_done | output | 1 | Command response strobe |
| wr_status | output | 2 | 0 success, 1 parameter error |
| lk_valid | input | 1 | Lookup strobe |
| lk_rid | input | 16 | Requester ID to classify |
| lk_done | output | 1 | Lookup response strobe |
| lk_hit | output | 1 | A valid rule accepted the ID |
| lk_part | output | PART_W | Partition of the winning rule, 0 on a miss |

## Verification
The bench builds the block with its default parameters: 16 rule slots and a 5-bit partition number. At that size the top and bottom slots are both reachable, and the priority tests can place overlapping rules at slots 4, 9 and 15. Rule slot 3 is rewritten with every class of bus compare code. This covers the wildcard code, prefix lengths at both ends of the 2–6 range and the full compare. Illegal codes and illegal actions are then applied to a live rule, to show that its previous lookup result survives.

// File: rtl/rpm_pkg.sv
package rpm_pkg;

  localparam int BUS_W  = 8;
  localparam int DEV_W  = 5;
  localparam int FUNC_W = 3;
  localparam int RID_W  = BUS_W + DEV_W + FUNC_W;

  localparam logic [1:0] ACT_UNMAP = 2'd0;
  localparam logic [1:0] ACT_MAP   = 2'd1;

  localparam logic [1:0] ST_OK  = 2'd0;
  localparam logic [1:0] ST_ERR = 2'd1;

  typedef struct packed {
    logic [BUS_W-1:0]  bus_mask;
    logic [BUS_W-1:0]  bus;
    logic              dev_on;
    logic [DEV_W-1:0]  dev;
    logic              func_on;
    logic [FUNC_W-1:0] func;
  } rule_t;

  // Legal bus codes: 0 (wildcard) and 2..7 (prefix of code+1 bits).
  function automatic logic bus_code_ok(input logic [3:0] code);
    return (code == 4'd0) || ((code >= 4'd2) && (code <= 4'd7));
  endfunction

  function automatic logic [BUS_W-1:0] bus_mask_of(input logic [3:0] code);
    logic [BUS_W-1:0] m;
    m = '0;
    for (int b = 0; b < BUS_W; b++) begin
      if ((code != 4'd0) && (b >= (BUS_W - 1 - int'(code))))
        m[b] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/rpm_cmd_decode.sv
module rpm_cmd_decode
  import rpm_pkg::*;
(
  input  logic       wr_valid,
  input  logic [1:0] action,
  input  logic [3:0] bus_code,
  output logic       we,
  output logic       set_valid,
  output logic [1:0] status
);

  logic act_ok;
  logic code_ok;

  always_comb begin
    act_ok    = (action == ACT_MAP) || (action == ACT_UNMAP);
    code_ok   = (action == ACT_UNMAP) || bus_code_ok(bus_code);
    we        = wr_valid && act_ok && code_ok;
    set_valid = (action == ACT_MAP);
    status    = (act_ok && code_ok) ? ST_OK : ST_ERR;
  end

endmodule

// File: rtl/rpm_rule_table.sv
module rpm_rule_table
  import rpm_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int PART_W      = 5,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [IDX_W-1:0]       idx,
  input  logic                   set_valid,
  input  rule_t                  rule_in,
  input  logic [PART_W-1:0]      part_in,
  output logic [NUM_ENTRIES-1:0] valid_o,
  output rule_t                  rule_o [NUM_ENTRIES],
  output logic [PART_W-1:0]      part_o [NUM_ENTRIES]
);

  logic [NUM_ENTRIES-1:0] valid_q;
  rule_t                  rule_q [NUM_ENTRIES];
  logic [PART_W-1:0]      part_q [NUM_ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else if (we) begin
      valid_q[idx] <= set_valid;
    end
  end

  // Rule payload carries no reset; the valid bit gates it.
  always_ff @(posedge clk) begin
    if (we && set_valid) begin
      rule_q[idx] <= rule_in;
      part_q[idx] <= part_in;
    end
  end

  assign valid_o = valid_q;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_out
    assign rule_o[g] = rule_q[g];
    assign part_o[g] = part_q[g];
  end

  AST_TABLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(valid_q)); // R6

  AST_RESET_EMPTY: assert property (@(posedge clk)
    rst |=> (valid_q == '0)); // R11

endmodule

// File: rtl/rpm_rule_match.sv
module rpm_rule_match
  import rpm_pkg::*;
(
  input  logic             valid,
  input  rule_t            rule,
  input  logic [RID_W-1:0] rid,
  output logic             hit
);

  logic [BUS_W-1:0]  rid_bus;
  logic [DEV_W-1:0]  rid_dev;
  logic [FUNC_W-1:0] rid_func;
  logic              bus_ok;
  logic              dev_ok;
  logic              func_ok;

  always_comb begin
    rid_bus  = rid[RID_W-1 -: BUS_W];
    rid_dev  = rid[FUNC_W +: DEV_W];
    rid_func = rid[FUNC_W-1:0];
    bus_ok   = ((rid_bus ^ rule.bus) & rule.bus_mask) == '0;
    dev_ok   = !rule.dev_on  || (rid_dev  == rule.dev);
    func_ok  = !rule.func_on || (rid_func == rule.func);
    hit      = valid && bus_ok && dev_ok && func_ok;
  end

endmodule

// File: rtl/rpm_prio_pick.sv
module rpm_prio_pick #(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_ENTRIES-1:0] hits,
  output logic                   any,
  output logic [IDX_W-1:0]       idx
);

  logic [NUM_ENTRIES-1:0] grant;

  always_comb begin
    any   = 1'b0;
    idx   = '0;
    grant = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (hits[i]) begin
        any   = 1'b1;
        idx   = IDX_W'(i);
        grant = '0;
        grant[i] = 1'b1;
      end
    end
  end

  AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant)); // R10

  AST_WINNER_HITS: assert property (@(posedge clk) disable iff (rst)
    any |-> hits[idx]); // R10

endmodule

// File: rtl/reqid_part_match.sv
module reqid_part_match
  import rpm_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int PART_W      = 5,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [IDX_W-1:0]  wr_index,
  input  logic [1:0]        wr_action,
  input  logic [PART_W-1:0] wr_part,
  input  logic [15:0]       wr_rid,
  input  logic [3:0]        wr_bus_code,
  input  logic [7:0]        wr_dev_cmp,
  input  logic [7:0]        wr_func_cmp,
  output logic              wr_done,
  output logic [1:0]        wr_status,
  input  logic              lk_valid,
  input  logic [15:0]       lk_rid,
  output logic              lk_done,
  output logic              lk_hit,
  output logic [PART_W-1:0] lk_part
);

  logic                   dec_we;
  logic                   dec_set;
  logic [1:0]             dec_status;
  rule_t                  new_rule;
  logic [NUM_ENTRIES-1:0] tbl_valid;
  rule_t                  tbl_rule [NUM_ENTRIES];
  logic [PART_W-1:0]      tbl_part [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] hits;
  logic                   any_hit;
  logic [IDX_W-1:0]       win_idx;

  rpm_cmd_decode u_dec (
    .wr_valid  (wr_valid),
    .action    (wr_action),
    .bus_code  (wr_bus_code),
    .we        (dec_we),
    .set_valid (dec_set),
    .status    (dec_status)
  );

  always_comb begin
    new_rule.bus_mask = bus_mask_of(wr_bus_code);
    new_rule.bus      = wr_rid[RID_W-1 -: BUS_W];
    new_rule.dev_on   = |wr_dev_cmp;
    new_rule.dev      = wr_rid[FUNC_W +: DEV_W];
    new_rule.func_on  = |wr_func_cmp;
    new_rule.func     = wr_rid[FUNC_W-1:0];
  end

  rpm_rule_table #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .PART_W      (PART_W)
  ) u_tbl (
    .clk       (clk),
    .rst       (rst),
    .we        (dec_we),
    .idx       (wr_index),
    .set_valid (dec_set),
    .rule_in   (new_rule),
    .part_in   (wr_part),
    .valid_o   (tbl_valid),
    .rule_o    (tbl_rule),
    .part_o    (tbl_part)
  );

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_match
    rpm_rule_match u_m (
      .valid (tbl_valid[g]),
      .rule  (tbl_rule[g]),
      .rid   (lk_rid),
      .hit   (hits[g])
    );
  end

  rpm_prio_pick #(
    .NUM_ENTRIES (NUM_ENTRIES)
  ) u_pick (
    .clk  (clk),
    .rst  (rst),
    .hits (hits),
    .any  (any_hit),
    .idx  (win_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_done   <= 1'b0;
      wr_status <= ST_OK;
      lk_done   <= 1'b0;
      lk_hit    <= 1'b0;
      lk_part   <= '0;
    end else begin
      wr_done   <= wr_valid;
      wr_status <= wr_valid ? dec_status : ST_OK;
      lk_done   <= lk_valid;
      lk_hit    <= lk_valid && any_hit;
      lk_part   <= (lk_valid && any_hit) ? tbl_part[win_idx] : '0;
    end
  end

  AST_WR_RESPONSE: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> wr_done); // R12

  AST_LK_RESPONSE: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> lk_done); // R9

  AST_LK_QUIET: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> (!lk_done && !lk_hit)); // R9

  AST_BAD_ACTION: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && (wr_action > 2'd1)) |=> (wr_status == ST_ERR)); // R6

  AST_BAD_BUS_CODE: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && (wr_action == ACT_MAP) && ((wr_bus_code == 4'd1) || (wr_bus_code > 4'd7)))
      |=> (wr_status == ST_ERR)); // R7

  AST_MISS_ZERO_PART: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (lk_part == '0)); // R11

endmodule

// File: tb/sim_reqid_part_match.sv
module sim_reqid_part_match;

  localparam int N  = 16;
  localparam int PW = 5;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_valid = 1'b0;
  logic [IW-1:0] wr_index = '0;
  logic [1:0]    wr_action = '0;
  logic [PW-1:0] wr_part = '0;
  logic [15:0]   wr_rid = '0;
  logic [3:0]    wr_bus_code = '0;
  logic [7:0]    wr_dev_cmp = '0;
  logic [7:0]    wr_func_cmp = '0;
  logic          wr_done;
  logic [1:0]    wr_status;
  logic          lk_valid = 1'b0;
  logic [15:0]   lk_rid = '0;
  logic          lk_done;
  logic          lk_hit;
  logic [PW-1:0] lk_part;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  reqid_part_match #(.NUM_ENTRIES(N), .PART_W(PW)) u0 (
    .clk(clk), .rst(rst),
    .wr_valid(wr_valid), .wr_index(wr_index), .wr_action(wr_action),
    .wr_part(wr_part), .wr_rid(wr_rid), .wr_bus_code(wr_bus_code),
    .wr_dev_cmp(wr_dev_cmp), .wr_func_cmp(wr_func_cmp),
    .wr_done(wr_done), .wr_status(wr_status),
    .lk_valid(lk_valid), .lk_rid(lk_rid),
    .lk_done(lk_done), .lk_hit(lk_hit), .lk_part(lk_part)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_write(input int idx, input int act, input int part, input int rid,
                          input int code, input int dcmp, input int fcmp,
                          input int exp_st, input string tag);
    @(negedge clk);
    wr_valid = 1'b1; wr_index = IW'(idx); wr_action = 2'(act); wr_part = PW'(part);
    wr_rid = 16'(rid); wr_bus_code = 4'(code); wr_dev_cmp = 8'(dcmp); wr_func_cmp = 8'(fcmp);
    @(negedge clk);
    wr_valid = 1'b0;
    check({tag, " R12 wr_done"}, int'(wr_done), 1);
    check({tag, " status"}, int'(wr_status), exp_st);
  endtask

  task automatic do_look(input int rid, input int exp_hit, input int exp_part, input string tag);
    @(negedge clk);
    lk_valid = 1'b1; lk_rid = 16'(rid);
    @(negedge clk);
    lk_valid = 1'b0;
    check({tag, " R9 lk_done"}, int'(lk_done), 1);
    check({tag, " hit"}, int'(lk_hit), exp_hit);
    check({tag, " part"}, int'(lk_part), exp_part);
  endtask

  task automatic t_reset();
    check("R11 reset wr_done", int'(wr_done), 0);
    check("R9 reset lk_done", int'(lk_done), 0);
    do_look(16'h0000, 0, 0, "R11 empty table");
    do_look(16'hFFFF, 0, 0, "R11 empty table top");
  endtask

  task automatic t_bus_codes();
    do_write(3, 1, 7, 16'h5A00, 0, 0, 0, 0, "R6 map code0");
    do_look(16'hFF13, 1, 7, "R1 any bus");
    do_write(3, 1, 7, 16'h5A00, 2, 0, 0, 0, "R2 map code2");
    do_look(16'h5F00, 1, 7, "R2 top3 equal");
    do_look(16'h7A00, 0, 0, "R2 top3 differ");
    do_write(3, 1, 7, 16'h5A00, 6, 0, 0, 0, "R2 map code6");
    do_look(16'h5B00, 1, 7, "R2 top7 equal");
    do_look(16'h5800, 0, 0, "R2 top7 differ");
    do_write(3, 1, 7, 16'h5A00, 7, 0, 0, 0, "R3 map code7");
    do_look(16'h5AFF, 1, 7, "R3 exact bus");
    do_look(16'h5B00, 0, 0, "R3 lsb differs");
  endtask

  task automatic t_dev_func();
    do_write(3, 1, 11, 16'h002A, 0, 1, 0, 0, "R4 map dev5");
    do_look(16'h3329, 1, 11, "R4 R8 dev5 func1");
    do_look(16'h0032, 0, 0, "R4 R8 dev6");
    do_write(3, 1, 11, 16'h0012, 0, 0, 2, 0, "R5 map func2");
    do_look(16'h00F2, 1, 11, "R5 R8 func2 other dev");
    do_look(16'h0013, 0, 0, "R5 R8 func3");
    do_write(3, 1, 11, 16'h0012, 0, 8'h80, 8'h40, 0, "R4 R5 map both");
    do_look(16'h0012, 1, 11, "R4 R5 exact");
    do_look(16'h001A, 0, 0, "R4 dev differs");
  endtask

  task automatic t_rejects();
    do_write(3, 2, 30, 16'hFFFF, 0, 0, 0, 1, "R6 action2");
    do_write(3, 3, 30, 16'hFFFF, 0, 0, 0, 1, "R6 action3");
    do_look(16'h0012, 1, 11, "R6 table kept");
    do_write(3, 1, 30, 16'hFFFF, 1, 0, 0, 1, "R7 code1");
    do_write(3, 1, 30, 16'hFFFF, 9, 0, 0, 1, "R7 code9");
    do_look(16'h0012, 1, 11, "R7 table kept");
    do_look(16'hFFFF, 0, 0, "R7 no new rule");
  endtask

  task automatic t_unmap();
    do_write(3, 0, 0, 0, 9, 0, 0, 0, "R7 unmap bad code ok");
    do_look(16'h0012, 0, 0, "R11 unmapped");
  endtask

  task automatic t_priority();
    do_write(15, 1, 31, 16'h0000, 0, 0, 0, 0, "R10 map 15");
    do_write(9, 1, 21, 16'h1000, 2, 0, 0, 0, "R10 map 9");
    do_write(4, 1, 12, 16'h1000, 7, 0, 0, 0, "R10 map 4");
    do_look(16'h1000, 1, 12, "R10 slot4 wins");
    do_look(16'h1100, 1, 21, "R10 slot9 wins");
    do_look(16'hE000, 1, 31, "R10 slot15 only");
    do_write(4, 0, 0, 0, 0, 0, 0, 0, "R6 unmap 4");
    do_look(16'h1000, 1, 21, "R11 R10 after unmap");
  endtask

  task automatic t_latency();
    @(negedge clk);
    lk_valid = 1'b1; lk_rid = 16'h1000;
    wr_valid = 1'b1; wr_index = 4'd9; wr_action = 2'd0;
    @(negedge clk);
    lk_valid = 1'b0; wr_valid = 1'b0;
    check("R9 same-cycle old table hit", int'(lk_hit), 1);
    check("R9 same-cycle old table part", int'(lk_part), 21);
    @(negedge clk);
    check("R9 idle lk_done", int'(lk_done), 0);
    check("R9 idle lk_hit", int'(lk_hit), 0);
    check("R12 idle wr_done", int'(wr_done), 0);
    do_look(16'h1000, 1, 31, "R9 R10 write visible");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_bus_codes();
    t_dev_func();
    t_rejects();
    t_unmap();
    t_priority();
    t_latency();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule